// File: doc/BRIEF.md
# Transmit Queue Empty Interrupt and DMA Request Generator

This block holds a small byte-wide queue between a host and a serial shifter. The host pushes bytes and the shifter pops them, oldest first. From the fill level the block derives a "room available" condition. That condition drives three outputs: a level-sensitive buffer-empty interrupt, a primary DMA request, and a secondary DMA request pin.

A configuration register holds two bits, loaded by a single strobe. The level-select bit chooses the condition. When it is set, the condition is "queue completely empty". When it is clear, the condition is "the entry the host writes next is free", that is, the queue is not full. The release-timing bit chooses when the secondary request falls. When it is set, the secondary request falls together with the primary one. When it is clear, the secondary request stays high for a fixed number of extra clocks after the primary one drops.

A write to a full queue is dropped, and a sticky overflow flag is raised. Both an asynchronous hardware reset and a synchronous channel reset return the queue, the flag and the configuration to their reset state.

Top module: `txq_req_gen`

## Requirements
- R1: Popped bytes leave in write order. `rd_data` shows the oldest byte whenever `rd_valid` is 1, and `rd_valid` is 1 exactly when the queue holds at least one byte. A pop of an empty queue does nothing.
- R2: A write while the queue holds DEPTH (default 4) bytes is dropped: the stored bytes and their order are unchanged. It sets `overflow`, which then stays 1 until a reset.
- R3: With the level-select bit at 1, the condition is true only when the queue holds zero bytes.
- R4: With the level-select bit at 0, the condition is true whenever the queue holds fewer than DEPTH bytes.
- R5: `tbe_irq` equals `irq_en` AND the condition. It is level-sensitive and follows the fill level registered at the last clock edge.
- R6: `dma_req` equals `dma_en` AND the condition. It falls in the cycle right after the clock edge that captured the host write removing the condition.
- R7: `dma_req2` is 0 whenever `dma_en` or `req2_en` is 0. With both at 1, it rises together with `dma_req`.
- R8: With the release-timing bit at 1, `dma_req2` falls together with `dma_req`. With it at 0, `dma_req2` stays 1 for exactly HOLD_CYC (default 4) further clocks after `dma_req` falls, unless the condition returns first.
- R9: `rst_n` low (asynchronous) or `chan_rst` high at a clock edge empties the queue, clears `overflow` and the hold timer, sets the level-select bit to 1 and clears the release-timing bit.
- R10: `cfg_wr` at a clock edge loads `cfg_level` into the level-select bit and `cfg_fast` into the release-timing bit. The new values take effect in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| wr_en | input | 1 | Host push strobe |
| wr_data | input | WIDTH | Byte pushed by the host |
| rd_pop | input | 1 | Shifter pop strobe |
| cfg_wr | input | 1 | Load strobe for the configuration bits |
| cfg_level | input | 1 | Level-select value: 1 means completely empty, 0 means next entry free |
| cfg_fast | input | 1 | Release-timing value: 1 means secondary falls with primary, 0 means delayed |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request-on-transmit mode enable |
| req2_en | input | 1 | Enables request mode on the secondary pin |
| rd_data | output | WIDTH | Oldest queued byte |
| rd_valid | output | 1 | Queue not empty |
| overflow | output | 1 | Sticky flag for a write to a full queue |
| tbe_irq | output | 1 | Buffer-empty interrupt |
| dma_req | output | 1 | Primary DMA request |
| dma_req2 | output | 1 | Secondary DMA request |

## Verification
The hardest situation to reach is a delayed secondary release that is cut short. The queue must be filled past the condition, so that the hold timer starts. Then, within HOLD_CYC clocks, a pop, a disable or a configuration change must land. Random push/pop stimulus alone rarely lines these up. The bench therefore biases its push and pop rates by fill level, so it crosses the not-full and empty boundaries often, and toggles the enables and configuration at random. Directed sequences pin down the exact four-cycle tail, the immediate release, and a write into a full queue.

// File: rtl/txq_pkg.sv
package txq_pkg;
   // selects which fill condition drives the request outputs
   typedef enum logic {
      COND_NOT_FULL = 1'b0,
      COND_EMPTY    = 1'b1
   } cond_sel_e;

   typedef struct packed {
      cond_sel_e level;
      logic      fast;
   } txq_cfg_t;

   localparam txq_cfg_t CFG_RESET = '{level: COND_EMPTY, fast: 1'b0};
endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [$clog2(DEPTH+1)-1:0] fill,
   output logic             ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
         $error("txq_store: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("txq_store: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic             do_push, do_pop, is_full;

   assign is_full = (fill == FULL_CNT);
   assign do_push = push && !is_full;
   assign do_pop  = pop && (fill != '0);
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
         ovf  <= 1'b0;
      end else if (clr) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
         ovf  <= 1'b0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop)  rp <= rp + AW'(1);
         fill <= fill + CW'(do_push) - CW'(do_pop);
         if (push && is_full) ovf <= 1'b1;
      end
   end

   // R2
   full_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (is_full && push && !pop) |=> (fill == FULL_CNT));
   // R2
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      ovf |=> ovf);
   // R1
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_CNT);
endmodule

// File: rtl/txq_cond.sv
module txq_cond
   import txq_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  cond_sel_e                  level,
   input  logic [$clog2(DEPTH+1)-1:0] fill,
   output logic                       room
);
   localparam int CW = $clog2(DEPTH+1);

   always_comb begin
      unique case (level)
         COND_EMPTY:    room = (fill == '0);
         COND_NOT_FULL: room = (fill < CW'(DEPTH));
         default:       room = 1'b0;
      endcase
   end

   // R3
   empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level == COND_EMPTY && fill != '0) |-> !room);
   // R4
   notfull_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level == COND_NOT_FULL && fill == CW'(DEPTH)) |-> !room);
endmodule

// File: rtl/txq_req2.sv
module txq_req2 #(
   parameter int HOLD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic active,
   input  logic room,
   input  logic fast,
   output logic req2
);
   generate
      if (HOLD_CYC < 0) begin : g_bad_hold
         $error("txq_req2: HOLD_CYC must not be negative");
      end
      if (HOLD_CYC == 0) begin : g_no_hold
         assign req2 = active && room;
      end else begin : g_hold
         localparam int HW = $clog2(HOLD_CYC+1);
         logic [HW-1:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                hold <= '0;
            else if (clr)              hold <= '0;
            else if (active && room)   hold <= HW'(HOLD_CYC);
            else if (hold != '0)       hold <= hold - HW'(1);
         end
         assign req2 = active && (room || (!fast && hold != '0));
      end
   endgenerate

   // R7
   req2_gated_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      !active |-> !req2);
   // R8
   req2_fast_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (active && fast) |-> (req2 == room));
endmodule

// File: rtl/txq_req_gen.sv
module txq_req_gen
   import txq_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int DEPTH    = 4,
   parameter int HOLD_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_pop,
   input  logic             cfg_wr,
   input  logic             cfg_level,
   input  logic             cfg_fast,
   input  logic             irq_en,
   input  logic             dma_en,
   input  logic             req2_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   output logic             overflow,
   output logic             tbe_irq,
   output logic             dma_req,
   output logic             dma_req2
);
   localparam int CW = $clog2(DEPTH+1);

   txq_cfg_t      cfg;
   logic [CW-1:0] fill;
   logic          room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg <= CFG_RESET;
      else if (chan_rst) cfg <= CFG_RESET;
      else if (cfg_wr)   cfg <= '{level: cond_sel_e'(cfg_level), fast: cfg_fast};
   end

   txq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(chan_rst),
      .push(wr_en), .din(wr_data), .pop(rd_pop),
      .dout(rd_data), .fill(fill), .ovf(overflow)
   );

   txq_cond #(.DEPTH(DEPTH)) u_cond (
      .clk(clk), .rst_n(rst_n), .level(cfg.level), .fill(fill), .room(room)
   );

   txq_req2 #(.HOLD_CYC(HOLD_CYC)) u_req2 (
      .clk(clk), .rst_n(rst_n), .clr(chan_rst),
      .active(dma_en && req2_en), .room(room), .fast(cfg.fast), .req2(dma_req2)
   );

   assign rd_valid = (fill != '0);
   assign tbe_irq  = irq_en && room;
   assign dma_req  = dma_en && room;

   // R5
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
      tbe_irq |-> irq_en);
   // R3
   irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n || chan_rst)
      (tbe_irq && cfg.level == COND_EMPTY) |-> !rd_valid);
   // R9
   chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst |=> (!rd_valid && !overflow));
endmodule

// File: tb/tb_txq_req_gen.sv
module tb_txq_req_gen;
   localparam int W = 8, D = 4, H = 4;
   localparam int MAXCYC = 200000;

   logic clk = 0, rst_n = 0, chan_rst = 0, wr_en = 0, rd_pop = 0;
   logic cfg_wr = 0, cfg_level = 0, cfg_fast = 0, irq_en = 0, dma_en = 0, req2_en = 0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic rd_valid, overflow, tbe_irq, dma_req, dma_req2;

   int vectors = 0, errors = 0;
   logic [W-1:0] q[$];
   bit m_ovf, m_lvl, m_fast;
   int m_hold;

   always #10 clk = ~clk;

   txq_req_gen #(.WIDTH(W), .DEPTH(D), .HOLD_CYC(H)) dut (.*);

   function automatic bit room_f();
      return m_lvl ? (q.size() == 0) : (q.size() < D);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      q.delete(); m_ovf = 0; m_lvl = 1; m_fast = 0; m_hold = 0;
   endtask

   // compares all outputs against the model
   task automatic compare();
      bit r, act2;
      r = room_f();
      act2 = dma_en && req2_en;
      vectors++;
      chk(rd_valid == (q.size() != 0), "R1 rd_valid", rd_valid, q.size() != 0);
      if (q.size() != 0) chk(rd_data == q[0], "R1 rd_data", rd_data, q[0]);
      chk(overflow == m_ovf, "R2 overflow", overflow, m_ovf);
      chk(tbe_irq == (irq_en && r), m_lvl ? "R3/R5 tbe_irq" : "R4/R5 tbe_irq", tbe_irq, irq_en && r);
      chk(dma_req == (dma_en && r), "R6 dma_req", dma_req, dma_en && r);
      chk(dma_req2 == (act2 && (r || (!m_fast && m_hold != 0))), "R7/R8 dma_req2",
          dma_req2, act2 && (r || (!m_fast && m_hold != 0)));
   endtask

   // one clock: inputs already set by caller, applied after the falling edge
   task automatic step();
      bit r, full;
      @(negedge clk);
      r = room_f();
      full = (q.size() == D);
      if (chan_rst) model_reset();
      else begin
         if (dma_en && req2_en && r) m_hold = H;
         else if (m_hold != 0) m_hold--;
         if (wr_en && full) m_ovf = 1;
         if (rd_pop && q.size() != 0) void'(q.pop_front());
         if (wr_en && !full) q.push_back(wr_data);
         if (cfg_wr) begin m_lvl = cfg_level; m_fast = cfg_fast; end
      end
      @(posedge clk); #1;
      compare();
   endtask

   task automatic idle();
      wr_en = 0; rd_pop = 0; cfg_wr = 0; chan_rst = 0;
   endtask

   task automatic set_cfg(input bit lvl, input bit fast);
      idle(); cfg_wr = 1; cfg_level = lvl; cfg_fast = fast; step(); cfg_wr = 0;
   endtask

   task automatic push(input logic [W-1:0] b);
      idle(); wr_en = 1; wr_data = b; step(); wr_en = 0;
   endtask

   initial begin
      #(20 * MAXCYC);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      irq_en = 1; dma_en = 1; req2_en = 1;
      #35 rst_n = 1;
      @(posedge clk); #1;
      // R9 reset state: empty, level=1 so all requests up
      compare();
      chk(dma_req == 1, "R9 level after reset", dma_req, 1);

      // R3: one byte drops requests; primary falls next cycle (R6)
      push(8'hA1);
      chk(dma_req == 0, "R6 falls after write", dma_req, 0);
      // R8: delayed release, secondary high for exactly H more clocks
      for (int i = 0; i < H; i++) begin
         chk(dma_req2 == 1, "R8 hold tail", dma_req2, 1);
         idle(); step();
      end
      chk(dma_req2 == 0, "R8 tail ended", dma_req2, 0);

      // R10 fast release; R4 not-full level
      idle(); rd_pop = 1; step(); rd_pop = 0;
      set_cfg(0, 1);
      for (int i = 0; i < D; i++) push(8'h10 + 8'(i));
      chk(dma_req == 0 && dma_req2 == 0, "R4/R8 full drops both", dma_req2, 0);
      // R2 write into full queue
      push(8'hEE);
      chk(overflow == 1, "R2 overflow set", overflow, 1);
      for (int i = 0; i < D; i++) begin
         chk(rd_data == 8'h10 + 8'(i), "R1/R2 order kept", rd_data, 8'h10 + i);
         idle(); rd_pop = 1; step();
      end
      idle(); rd_pop = 1; step();   // R1 pop of empty queue ignored
      chk(rd_valid == 0 && overflow == 1, "R1/R2 empty pop", rd_valid, 0);
      // R7 disable gating
      req2_en = 0; idle(); step();
      chk(dma_req2 == 0, "R7 gated", dma_req2, 1'b0);
      req2_en = 1;
      // R9 channel reset
      idle(); chan_rst = 1; step(); chan_rst = 0;
      chk(overflow == 0, "R9 channel reset", overflow, 0);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         int sz = q.size();
         idle();
         wr_en   = ($urandom % 8) < (sz < 2 ? 6 : 3);
         wr_data = W'($urandom);
         rd_pop  = ($urandom % 8) < (sz > 2 ? 6 : 2);
         cfg_wr  = ($urandom % 40) == 0;
         cfg_level = $urandom; cfg_fast = $urandom;
         chan_rst = ($urandom % 300) == 0;
         if (($urandom % 25) == 0) irq_en = $urandom;
         if (($urandom % 25) == 0) dma_en = $urandom;
         if (($urandom % 25) == 0) req2_en = $urandom;
         step();
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule